// File: doc/BRIEF.md
# Shared Memory Slot Arbiter

This block decides, once per memory slot, which of two requesters may use a shared memory bus: a processor port or a block-transfer engine. Each slot is granted to exactly one of them or left idle. A slot can also be claimed in advance by display fetch, which outranks both requesters; such a slot stays idle from this block's point of view.

A mode flag selects between two policies. In hog mode the transfer engine wins every even slot it asks for. In polite mode the arbiter counts how many slots in a row the processor asked for and lost to the engine. Once that count reaches a limit (three by default), the engine is held off for one slot and the processor takes it. With both requesters asking all the time, the processor then gets one of every four even slots. Odd slots are never offered to the engine. The grants are registered, are one-hot or idle, and move only when the slot strobe is high.

Top module: `mem_slot_arbiter`

## Requirements
- R1: After reset both grant outputs are 0 and the starvation count is zero, so a polite-mode run with both requesters active grants the engine three slots before the processor gets one.
- R2: The two grant outputs are never high together. They update only on a clock edge where `slot_i` is 1, one edge after the strobe, and hold their value between strobes.
- R3: On a slot with `even_i` = 0 (odd slot) the engine is never granted. The processor gets the slot if it requests it; otherwise the slot is idle.
- R4: A slot with `disp_rsv_i` = 1 grants neither requester and leaves the starvation count unchanged.
- R5: With `hog_i` = 1 the engine is granted every unreserved even slot it requests, and the processor gets none of those slots, however long it has waited.
- R6: With `hog_i` = 0, after the processor has requested and lost STARVE_LIMIT (3) consecutive counted slots, the next unreserved slot goes to the processor and the engine is denied. With both requesting on every even slot, the pattern is engine, engine, engine, processor, repeating.
- R7: The starvation count returns to zero on any unreserved slot where the processor is granted or does not request.
- R8: On an unreserved slot where the engine does not request, the processor is granted if it requests, in both modes. With no request the slot is idle.
- R9: The mode flag is read at each strobe. The count keeps running, saturating at the limit, in both modes, so a switch from hog to polite after a long denial hands the very next slot to the processor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_i | input | 1 | Slot strobe: one slot is decided on each edge where this is 1 |
| even_i | input | 1 | 1 = the current slot is even (open to the engine), 0 = odd |
| cpu_req_i | input | 1 | Processor requests the slot |
| xfer_req_i | input | 1 | Transfer engine requests the slot |
| hog_i | input | 1 | 1 = hog mode, 0 = polite mode |
| disp_rsv_i | input | 1 | Slot is reserved by display fetch |
| cpu_gnt_o | output | 1 | Registered grant to the processor |
| xfer_gnt_o | output | 1 | Registered grant to the transfer engine |

## Verification
Every grant is due exactly one clock edge after the strobe that decided it. The bench therefore drives a slot's inputs at a falling edge with the strobe high, and reads the grants at the next falling edge, half a period after the edge that registered them. The hold checks leave the strobe low for several cycles while the other inputs toggle, and compare the grants at each falling edge. Starvation checks run as consecutive slots after a fresh reset, so the expected owner of every slot follows from counting that slot's predecessors.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    GNT_NONE = 2'b00,
    GNT_CPU  = 2'b01,
    GNT_XFER = 2'b10
  } gnt_e;
endpackage

// File: rtl/starve_ctr.sv
module starve_ctr #(
  parameter int STARVE_LIMIT = 3,
  localparam int CNT_W = $clog2(STARVE_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,   // unreserved slot decided
  input  logic             miss_i,   // cpu asked and lost
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_limit_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(STARVE_LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (step_i) begin
      if (!miss_i)          cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o      = cnt_q;
  assign at_limit_o = (cnt_q == LIM);

  a_r9_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  a_r7_cnt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !miss_i |=> cnt_q == '0);
  a_r4_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/slot_decide.sv
module slot_decide
  import arb_pkg::*;
(
  input  logic cpu_req_i,
  input  logic xfer_req_i,
  input  logic even_i,
  input  logic hog_i,
  input  logic rsv_i,
  input  logic starved_i,
  output gnt_e gnt_o,
  output logic miss_o
);
  logic xfer_win;

  // engine only on even slots; polite mode yields once cpu is starved
  assign xfer_win = !rsv_i && xfer_req_i && even_i && (hog_i || !starved_i);

  always_comb begin
    if (rsv_i)              gnt_o = GNT_NONE;
    else if (xfer_win)      gnt_o = GNT_XFER;
    else if (cpu_req_i)     gnt_o = GNT_CPU;
    else                    gnt_o = GNT_NONE;
  end

  assign miss_o = cpu_req_i && xfer_win;
endmodule

// File: rtl/mem_slot_arbiter.sv
module mem_slot_arbiter
  import arb_pkg::*;
#(
  parameter int STARVE_LIMIT = 3,
  localparam int CNT_W = $clog2(STARVE_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slot_i,
  input  logic even_i,
  input  logic cpu_req_i,
  input  logic xfer_req_i,
  input  logic hog_i,
  input  logic disp_rsv_i,
  output logic cpu_gnt_o,
  output logic xfer_gnt_o
);
  gnt_e             gnt_d, gnt_q;
  logic             miss, starved;
  logic [CNT_W-1:0] cnt;

  slot_decide u_decide (
    .cpu_req_i (cpu_req_i),
    .xfer_req_i(xfer_req_i),
    .even_i    (even_i),
    .hog_i     (hog_i),
    .rsv_i     (disp_rsv_i),
    .starved_i (starved),
    .gnt_o     (gnt_d),
    .miss_o    (miss)
  );

  starve_ctr #(.STARVE_LIMIT(STARVE_LIMIT)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (slot_i && !disp_rsv_i),
    .miss_i    (miss),
    .cnt_o     (cnt),
    .at_limit_o(starved)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gnt_q <= GNT_NONE;
    else if (slot_i) gnt_q <= gnt_d;
  end

  assign cpu_gnt_o  = (gnt_q == GNT_CPU);
  assign xfer_gnt_o = (gnt_q == GNT_XFER);

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cpu_gnt_o, xfer_gnt_o}));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> $stable({cpu_gnt_o, xfer_gnt_o}));
  a_r3_no_odd_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i && !even_i |=> !xfer_gnt_o);
  a_r4_rsv_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i && disp_rsv_i |=> !cpu_gnt_o && !xfer_gnt_o);
  a_r5_hog_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i && hog_i && even_i && xfer_req_i && !disp_rsv_i |=> xfer_gnt_o);
  a_r6_yield: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i && !hog_i && !disp_rsv_i && cpu_req_i && cnt == CNT_W'(STARVE_LIMIT)
    |=> cpu_gnt_o);
  a_r8_cpu_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i && !disp_rsv_i && cpu_req_i && !(xfer_req_i && even_i) |=> cpu_gnt_o);
endmodule

// File: tb/tb_mem_slot_arbiter.sv
module tb_mem_slot_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot = 1'b0, even = 1'b0, cpu_req = 1'b0, xfer_req = 1'b0, hog = 1'b0, rsv = 1'b0;
  logic cpu_gnt, xfer_gnt;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  mem_slot_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .slot_i(slot), .even_i(even),
    .cpu_req_i(cpu_req), .xfer_req_i(xfer_req), .hog_i(hog),
    .disp_rsv_i(rsv), .cpu_gnt_o(cpu_gnt), .xfer_gnt_o(xfer_gnt)
  );

  task automatic check(input string req, input logic ec, input logic ex);
    checks++;
    if (cpu_gnt !== ec || xfer_gnt !== ex) begin
      errors++;
      $display("FAIL %s: cpu/xfer = %b%b expected %b%b", req, cpu_gnt, xfer_gnt, ec, ex);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; slot = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one slot: strobe for one edge, result read at the following falling edge
  task automatic do_slot(input string req, input logic c, input logic x, input logic e,
                         input logic h, input logic r, input logic ec, input logic ex);
    @(negedge clk);
    slot = 1'b1; cpu_req = c; xfer_req = x; even = e; hog = h; rsv = r;
    @(negedge clk);
    slot = 1'b0;
    check(req, ec, ex);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) do_slot("R1 count starts at zero", 1, 1, 1, 0, 0, 0, 1);
    do_slot("R1 first yield", 1, 1, 1, 0, 0, 1, 0);
  endtask

  task automatic t_hold;
    do_reset();
    do_slot("R2 grant", 0, 1, 1, 1, 0, 0, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cpu_req = 1'b1; xfer_req = 1'(i & 1); even = 1'b0; rsv = 1'(i >> 1);
      check("R2 hold without strobe", 0, 1);
    end
  endtask

  task automatic t_odd;
    do_reset();
    do_slot("R3 odd polite", 1, 1, 0, 0, 0, 1, 0);
    do_slot("R3 odd hog", 1, 1, 0, 1, 0, 1, 0);
    do_slot("R3 odd engine only", 0, 1, 0, 1, 0, 0, 0);
  endtask

  task automatic t_rsv;
    do_reset();
    do_slot("R4 pre", 1, 1, 1, 0, 0, 0, 1);
    do_slot("R4 pre", 1, 1, 1, 0, 0, 0, 1);
    do_slot("R4 reserved idle", 1, 1, 1, 0, 1, 0, 0);
    do_slot("R4 count kept", 1, 1, 1, 0, 0, 0, 1);
    do_slot("R4 yield after kept count", 1, 1, 1, 0, 0, 1, 0);
  endtask

  task automatic t_hog;
    do_reset();
    for (int i = 0; i < 6; i++) do_slot("R5 hog takes every even", 1, 1, 1, 1, 0, 0, 1);
  endtask

  task automatic t_polite;
    do_reset();
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 3; i++) do_slot("R6 engine slot", 1, 1, 1, 0, 0, 0, 1);
      do_slot("R6 cpu one in four", 1, 1, 1, 0, 0, 1, 0);
    end
  endtask

  task automatic t_clear;
    do_reset();
    do_slot("R7 pre", 1, 1, 1, 0, 0, 0, 1);
    do_slot("R7 pre", 1, 1, 1, 0, 0, 0, 1);
    do_slot("R7 cpu idle clears", 0, 1, 1, 0, 0, 0, 1);
    for (int i = 0; i < 3; i++) do_slot("R7 recount", 1, 1, 1, 0, 0, 0, 1);
    do_slot("R7 yield", 1, 1, 1, 0, 0, 1, 0);
    do_slot("R7 grant clears", 1, 1, 1, 0, 0, 0, 1);
  endtask

  task automatic t_alone;
    do_reset();
    do_slot("R8 cpu alone hog", 1, 0, 1, 1, 0, 1, 0);
    do_slot("R8 cpu alone polite", 1, 0, 1, 0, 0, 1, 0);
    do_slot("R8 nobody", 0, 0, 1, 0, 0, 0, 0);
  endtask

  task automatic t_mode;
    do_reset();
    for (int i = 0; i < 5; i++) do_slot("R9 hog saturates", 1, 1, 1, 1, 0, 0, 1);
    do_slot("R9 switch to polite yields", 1, 1, 1, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) do_slot("R9 polite count", 1, 1, 1, 0, 0, 0, 1);
    do_slot("R9 switch to hog ignores count", 1, 1, 1, 1, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_hold();
    t_odd();
    t_rsv();
    t_hog();
    t_polite();
    t_clear();
    t_alone();
    t_mode();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule